// File: doc/BRIEF.md
# Four-Digit Clock Display Scanner

This block drives an hours:minutes clock face of four seven-segment digits through a single shared BCD decode path. On each scan slot it selects one digit, steers that digit's BCD value into the decoder and enables only that digit's anode driver. Because the digits are lit in turn, one decoder and one set of segment lines serve all four.

The scan slot is not counted locally. It is taken straight from two adjacent bits of a free-running prescaler count, so the four slots last exactly the same time and the scan rate follows the time base. A zero in the hours-tens position is blanked so that times before ten o'clock show no leading zero. A separate colon enable blinks with a one-second phase input while the clock runs, and stays dark while the clock is being set.

Segment and digit enables are registered and reload only when a new slot begins. A changing digit input therefore cannot disturb the segments in the middle of a slot. Two parameters choose the active level of the segment lines and of the digit enables independently, to suit whichever external driver stages follow the block. The checks below assume the default of active-high levels for both.

Top module: `digit_scan_display`

## Requirements
- R1: Out of reset, exactly one bit of `digitEn` is active at a time, and none is active while reset holds.
- R2: The scan slot is `prescaleCnt[SEL_LO_BIT+1:SEL_LO_BIT]`, with bit `SEL_LO_BIT` as the low-order bit. The other prescaler bits have no effect on any output.
- R3: Slot 0 selects minutes units on `digitEn[0]`, slot 1 selects minutes tens on `digitEn[1]`, slot 2 selects hours units on `digitEn[2]`, and slot 3 selects hours tens on `digitEn[3]`. `segOut` bits 0..6 drive segments a..g. The patterns for 0..9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F.
- R4: `digitEn` and `segOut` reload at the clock edge where the sampled slot differs from the one seen at the previous edge, and at the first edge after reset. At every other edge they hold, even if the digit inputs change.
- R5: When slot 3 loads and `hoursTens` is 0, all segments are off.
- R6: A zero on minutes tens, minutes units or hours units is shown as the 0 pattern and is never blanked.
- R7: A selected digit holding a code from 10 to 15 turns all segments off.
- R8: While `runMode` is 1, `colonEn` follows `secPhase` one clock later, independent of the scan slot.
- R9: While `runMode` is 0, `colonEn` is 0 one clock later, whatever `secPhase` is.
- R10: A synchronous active-high `rst` turns all digit enables, segments and the colon off, and the scan reloads from the current slot at the first edge after its release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| prescaleCnt | input | PRESCALE_W | Free-running prescaler count |
| runMode | input | 1 | 1 when the clock is running, 0 while it is being set |
| secPhase | input | 1 | One-second phase, toggling once a second |
| hoursTens | input | 4 | BCD hours tens digit |
| hoursUnits | input | 4 | BCD hours units digit |
| minsTens | input | 4 | BCD minutes tens digit |
| minsUnits | input | 4 | BCD minutes units digit |
| digitEn | output | 4 | One-hot digit anode enables |
| segOut | output | 7 | Segment lines a..g |
| colonEn | output | 1 | Colon enable |

## Verification
The bench goes after leading-zero blanking on the hours-tens slot, including the first load after reset. A design that blanked on the wrong slot would darken a legitimate zero in the minutes digits. One that never blanked would show "0" before ten o'clock. It changes digit values in the middle of a slot and toggles the unused prescaler bits. A design that reloaded on every edge would let the segments change within a slot, and one that decoded the wrong prescaler bits would jump digits. It also drives codes 10 to 15, checks that set mode darkens the colon even while the phase is high, and applies a reset in the middle of a scan. Its checks would catch leftover garbage segments, a colon that ignored the mode, or a scan that did not restart cleanly.

// File: rtl/scan_disp_pkg.sv
package scan_disp_pkg;

  localparam int NUM_DIGITS = 4;
  localparam int BCD_W      = 4;
  localparam int SEG_W      = 7;
  localparam int SLOT_W     = $clog2(NUM_DIGITS);

  // Strobes from the scan control to the datapath
  typedef struct packed {
    logic              clear;
    logic              load;
    logic [SLOT_W-1:0] slot;
  } scanStrobe_t;

  // Logical (active-high) segment pattern, bit0 = a ... bit6 = g
  function automatic logic [SEG_W-1:0] bcdToSeg(input logic [BCD_W-1:0] v);
    logic [SEG_W-1:0] s;
    case (v)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_disp_pkg::*;
#(
  parameter int PRESCALE_W = 15,
  parameter int SEL_LO_BIT = 7
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PRESCALE_W-1:0] prescaleCnt,
  output scanStrobe_t           strobe
);

  localparam int SEL_HI_BIT = SEL_LO_BIT + SLOT_W - 1;

  logic [SLOT_W-1:0] slotNow;
  logic [SLOT_W-1:0] slotPrev;
  logic              running;
  logic              unusedPrescale;

  assign slotNow        = prescaleCnt[SEL_HI_BIT:SEL_LO_BIT];
  assign unusedPrescale = ^prescaleCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      slotPrev <= '0;
    end else begin
      running  <= 1'b1;
      slotPrev <= slotNow;
    end
  end

  always_comb begin
    strobe.clear = rst;
    strobe.load  = !rst && (!running || (slotNow != slotPrev));
    strobe.slot  = slotNow;
  end

endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_disp_pkg::*;
#(
  parameter bit SEG_ACTIVE_HIGH = 1'b1,
  parameter bit DIG_ACTIVE_HIGH = 1'b1
) (
  input  logic                               clk,
  input  scanStrobe_t                        strobe,
  input  logic [NUM_DIGITS-1:0][BCD_W-1:0]   digitBcd,
  input  logic                               runMode,
  input  logic                               secPhase,
  output logic [NUM_DIGITS-1:0]              digitEn,
  output logic [SEG_W-1:0]                   segOut,
  output logic                               colonEn
);

  localparam int MSD_SLOT = NUM_DIGITS - 1;

  logic [BCD_W-1:0]      muxBcd;
  logic [NUM_DIGITS-1:0] slotHit;
  logic [SEG_W-1:0]      segNext;
  logic                  leadBlank;
  logic [SEG_W-1:0]      segQ;
  logic [NUM_DIGITS-1:0] digQ;
  logic                  colonQ;

  // One 4-to-1 selector per BCD bit
  for (genvar b = 0; b < BCD_W; b++) begin : gBitMux
    logic [NUM_DIGITS-1:0] column;
    for (genvar d = 0; d < NUM_DIGITS; d++) begin : gCol
      assign column[d] = digitBcd[d][b];
    end
    assign muxBcd[b] = column[strobe.slot];
  end

  // Slot to one-hot digit enable
  for (genvar d = 0; d < NUM_DIGITS; d++) begin : gHit
    assign slotHit[d] = (strobe.slot == SLOT_W'(d));
  end

  assign leadBlank = (strobe.slot == SLOT_W'(MSD_SLOT)) && (muxBcd == '0);
  assign segNext   = leadBlank ? '0 : bcdToSeg(muxBcd);

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      segQ   <= '0;
      digQ   <= '0;
      colonQ <= 1'b0;
    end else begin
      if (strobe.load) begin
        segQ <= segNext;
        digQ <= slotHit;
      end
      colonQ <= runMode && secPhase;
    end
  end

  if (SEG_ACTIVE_HIGH) begin : gSegHi
    assign segOut = segQ;
  end else begin : gSegLo
    assign segOut = ~segQ;
  end

  if (DIG_ACTIVE_HIGH) begin : gDigHi
    assign digitEn = digQ;
  end else begin : gDigLo
    assign digitEn = ~digQ;
  end

  assign colonEn = colonQ;

endmodule

// File: rtl/digit_scan_display.sv
module digit_scan_display
  import scan_disp_pkg::*;
#(
  parameter int PRESCALE_W      = 15,
  parameter int SEL_LO_BIT      = 7,
  parameter bit SEG_ACTIVE_HIGH = 1'b1,
  parameter bit DIG_ACTIVE_HIGH = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [PRESCALE_W-1:0] prescaleCnt,
  input  logic                  runMode,
  input  logic                  secPhase,
  input  logic [3:0]            hoursTens,
  input  logic [3:0]            hoursUnits,
  input  logic [3:0]            minsTens,
  input  logic [3:0]            minsUnits,
  output logic [3:0]            digitEn,
  output logic [6:0]            segOut,
  output logic                  colonEn
);

  scanStrobe_t                      strobe;
  logic [NUM_DIGITS-1:0][BCD_W-1:0] digitBcd;

  // Index equals scan slot: 0 minutes units ... 3 hours tens
  assign digitBcd = {hoursTens, hoursUnits, minsTens, minsUnits};

  scan_ctrl #(
    .PRESCALE_W (PRESCALE_W),
    .SEL_LO_BIT (SEL_LO_BIT)
  ) uCtrl (
    .clk         (clk),
    .rst         (rst),
    .prescaleCnt (prescaleCnt),
    .strobe      (strobe)
  );

  scan_datapath #(
    .SEG_ACTIVE_HIGH (SEG_ACTIVE_HIGH),
    .DIG_ACTIVE_HIGH (DIG_ACTIVE_HIGH)
  ) uPath (
    .clk      (clk),
    .strobe   (strobe),
    .digitBcd (digitBcd),
    .runMode  (runMode),
    .secPhase (secPhase),
    .digitEn  (digitEn),
    .segOut   (segOut),
    .colonEn  (colonEn)
  );

endmodule

// File: rtl/scan_display_checker.sv
module scan_display_checker #(
  parameter bit SEG_ACTIVE_HIGH = 1'b1,
  parameter bit DIG_ACTIVE_HIGH = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] selIn,
  input logic       runMode,
  input logic       secPhase,
  input logic [3:0] hoursTens,
  input logic [3:0] digitEn,
  input logic [6:0] segOut,
  input logic       colonEn
);

  logic [3:0] actDig;
  logic [6:0] actSeg;

  assign actDig = DIG_ACTIVE_HIGH ? digitEn : ~digitEn;
  assign actSeg = SEG_ACTIVE_HIGH ? segOut  : ~segOut;

  assert_onehot_digits_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(actDig));

  assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (actDig == 4'd0) && (actSeg == 7'd0) && !colonEn);

  assert_hold_in_slot_R4: assert property (@(posedge clk) disable iff (rst)
    (selIn == $past(selIn)) && (actDig != 4'd0) |=> $stable(actSeg) && $stable(actDig));

  assert_lead_blank_R5: assert property (@(posedge clk) disable iff (rst)
    (selIn == 2'd3) && (hoursTens == 4'd0) && (selIn != $past(selIn)) |=> (actSeg == 7'd0));

  assert_colon_run_R8: assert property (@(posedge clk) disable iff (rst)
    runMode |=> (colonEn == $past(secPhase)));

  assert_colon_set_R9: assert property (@(posedge clk) disable iff (rst)
    !runMode |=> !colonEn);

endmodule

bind digit_scan_display scan_display_checker #(
  .SEG_ACTIVE_HIGH (SEG_ACTIVE_HIGH),
  .DIG_ACTIVE_HIGH (DIG_ACTIVE_HIGH)
) uChk (
  .clk       (clk),
  .rst       (rst),
  .selIn     (prescaleCnt[SEL_LO_BIT+1:SEL_LO_BIT]),
  .runMode   (runMode),
  .secPhase  (secPhase),
  .hoursTens (hoursTens),
  .digitEn   (digitEn),
  .segOut    (segOut),
  .colonEn   (colonEn)
);

// File: tb/tb_digit_scan_display.sv
module tb_digit_scan_display;

  localparam int PW = 15;
  localparam int LO = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [PW-1:0] prescaleCnt = '0;
  logic          runMode = 1'b0;
  logic          secPhase = 1'b0;
  logic [3:0]    hoursTens = '0, hoursUnits = '0, minsTens = '0, minsUnits = '0;
  logic [3:0]    digitEn;
  logic [6:0]    segOut;
  logic          colonEn;

  always #2 clk = ~clk;

  digit_scan_display #(.PRESCALE_W(PW), .SEL_LO_BIT(LO)) dut (
    .clk(clk), .rst(rst), .prescaleCnt(prescaleCnt), .runMode(runMode),
    .secPhase(secPhase), .hoursTens(hoursTens), .hoursUnits(hoursUnits),
    .minsTens(minsTens), .minsUnits(minsUnits), .digitEn(digitEn),
    .segOut(segOut), .colonEn(colonEn)
  );

  typedef struct {
    logic [3:0] dig;
    logic [6:0] seg;
    logic       colon;
    string      req;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference model state
  bit         mStarted = 1'b0;
  logic [1:0] mPrev = '0;
  logic [3:0] mDig = '0;
  logic [6:0] mSeg = '0;
  int         junk = 0;

  function automatic logic [6:0] refSeg(input logic [3:0] v);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                           7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    if (v > 4'd9) return 7'h00;
    return t[v];
  endfunction

  task automatic step(input logic r, input logic [1:0] sel,
                      input logic [3:0] ht, input logic [3:0] hu,
                      input logic [3:0] mt, input logic [3:0] mu,
                      input logic run, input logic ph, input string req);
    expItem_t e;
    logic [3:0] d;
    logic [PW-1:0] pc;
    @(negedge clk);
    junk = junk + 37;
    pc = PW'(junk * 131);
    pc[LO+1:LO] = sel;
    rst = r; prescaleCnt = pc; runMode = run; secPhase = ph;
    hoursTens = ht; hoursUnits = hu; minsTens = mt; minsUnits = mu;
    if (r) begin
      mStarted = 1'b0; mDig = '0; mSeg = '0;
      e.colon = 1'b0;
    end else begin
      if (!mStarted || sel != mPrev) begin
        case (sel)
          2'd0: d = mu;
          2'd1: d = mt;
          2'd2: d = hu;
          default: d = ht;
        endcase
        mDig = 4'(1 << sel);
        mSeg = (sel == 2'd3 && d == 4'd0) ? 7'h00 : refSeg(d);
      end
      mStarted = 1'b1;
      e.colon = run && ph;
    end
    mPrev = sel;
    e.dig = mDig; e.seg = mSeg; e.req = req;
    expQ.push_back(e);
  endtask

  // Monitor: compares after each edge
  initial begin
    expItem_t e;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        checks++;
        if (digitEn !== e.dig || segOut !== e.seg || colonEn !== e.colon) begin
          failures++;
          $display("FAIL %s: dig=%b seg=%h colon=%b expected dig=%b seg=%h colon=%b",
                   e.req, digitEn, segOut, colonEn, e.dig, e.seg, e.colon);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    for (int i = 0; i < 3; i++) step(1, 2'd0, 1, 2, 3, 4, 1, 1, "R10 reset");
    // R3/R1: first load and full scan
    step(0, 2'd0, 1, 2, 3, 4, 1, 1, "R3 slot0 first load");
    // R2: other prescaler bits vary, slot unchanged
    step(0, 2'd0, 1, 2, 3, 4, 1, 1, "R2 other bits");
    step(0, 2'd0, 1, 2, 3, 4, 1, 1, "R2 other bits");
    step(0, 2'd1, 1, 2, 3, 4, 1, 1, "R1 slot1");
    step(0, 2'd2, 1, 2, 3, 4, 1, 1, "R3 slot2");
    step(0, 2'd3, 1, 2, 3, 4, 1, 1, "R3 slot3");
    // R4: digit changes mid-slot must not show
    step(0, 2'd3, 2, 2, 3, 4, 1, 1, "R4 hold");
    step(0, 2'd3, 2, 5, 6, 7, 1, 1, "R4 hold");
    step(0, 2'd0, 2, 5, 6, 7, 1, 1, "R4 reload");
    // R5 and R6: zeros
    step(0, 2'd2, 0, 0, 0, 0, 1, 1, "R6 hours units zero");
    step(0, 2'd3, 0, 0, 0, 0, 1, 1, "R5 lead blank");
    step(0, 2'd3, 0, 0, 0, 0, 1, 1, "R5 lead blank hold");
    step(0, 2'd1, 0, 0, 0, 0, 1, 1, "R6 minutes tens zero");
    step(0, 2'd0, 0, 0, 0, 0, 1, 1, "R6 minutes units zero");
    // R3: decode sweep
    for (int v = 0; v < 10; v++)
      step(0, 2'(v % 2), 1, 1, 4'(v), 4'(v), 1, 0, "R3 decode");
    // R7: invalid codes
    for (int v = 10; v < 16; v++)
      step(0, 2'(v % 2), 1, 1, 4'(v), 4'(v), 1, 0, "R7 invalid code");
    step(0, 2'd3, 4'd12, 1, 1, 1, 1, 0, "R7 invalid hours tens");
    // R8: colon follows phase in run mode
    step(0, 2'd3, 1, 2, 3, 4, 1, 1, "R8 colon on");
    step(0, 2'd3, 1, 2, 3, 4, 1, 0, "R8 colon off");
    step(0, 2'd2, 1, 2, 3, 4, 1, 1, "R8 colon on");
    // R9: set mode
    step(0, 2'd2, 1, 2, 3, 4, 0, 1, "R9 set mode dark");
    step(0, 2'd1, 1, 2, 3, 4, 0, 1, "R9 set mode dark");
    step(0, 2'd0, 1, 2, 3, 4, 0, 0, "R9 set mode dark");
    // R10: mid-run reset and restart on slot 3 with leading zero
    step(1, 2'd0, 0, 9, 5, 8, 1, 1, "R10 mid reset");
    step(1, 2'd3, 0, 9, 5, 8, 1, 1, "R10 mid reset");
    step(0, 2'd3, 0, 9, 5, 8, 1, 1, "R5 blank on first load");
    step(0, 2'd2, 0, 9, 5, 8, 1, 1, "R10 restart scan");
    step(0, 2'd1, 0, 9, 5, 8, 1, 0, "R1 scan");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule